// File: doc/BRIEF.md
# Pin Event Interrupt Unit

This unit turns up to 24 pins of a general-purpose pin bank into interrupt request lines for a parent interrupt controller. Line k watches pin 120+k of the bank. Each line has an enable bit, a mode bit and a filter-enable bit. A fourth register holds one filter period that every line shares. The parent controller handles polarity and priority. This unit only decides what each request line shows.

Each line first passes its pin through a two-stage synchronizer and then through a glitch filter. The filter has two states. In FLT_SETTLED the accepted level matches the synchronized pin. FLT_SETTLED moves to FLT_QUALIFY when the sample differs. FLT_QUALIFY returns to FLT_SETTLED when the sample falls back (the glitch is rejected) or when the count reaches the period (the new level is accepted). With a period of 0, a differing sample is accepted at once without leaving FLT_SETTLED.

A per-line event machine drives the output. It has four states:
- EV_OFF: the line is disabled, invalid, or in both-edge mode without its filter. The output is high.
- EV_LEVEL: the line is in level mode. The output shows the filtered level, or the raw level when the filter is off.
- EV_ARMED: the line is in both-edge mode and waiting for an accepted change. The output is high.
- EV_FIRE: entered for one cycle on an accepted change. The output is low. EV_FIRE always returns to EV_ARMED, so a change accepted on the very next cycle merges into the same pulse.

The next state is recomputed every cycle from the configuration and the filter's change flag.

Top module: `pin_event_unit`

## Requirements
- R1: After reset, the enable, mode and filter registers read 0, the period register reads 0xFF, and every output is high.
- R2: The registers sit at these byte offsets: enable at 0x90, mode at 0x94 (bit value 1 selects both-edge), filter enable at 0x98, and period at 0x9C. Line k uses bit k of each of the first three. Only bits [23:0] of those three registers and bits [7:0] of the period register are stored, and read back zero-extended. A write to any other offset changes no register.
- R3: Line k is driven only by pin 120+k.
- R4: A line whose enable bit is 0 holds its output high.
- R5: In level mode with the filter off, the output equals the pin level. A pin change driven before clock edge 1 shows after edge 2.
- R6: In level mode with the filter on, a new level is accepted only after P+1 consecutive differing samples, where P is the period. A change driven before edge 1 shows after edge 3+P. A pulse of P pin cycles or fewer never reaches the output.
- R7: In both-edge mode with the filter on, every accepted change in either direction gives one low pulse exactly one cycle wide. A change driven before edge 1 gives the pulse after edge 4+P.
- R8: In both-edge mode with the filter off, the output stays high whatever the pin does.
- R9: One period value governs the filters of all lines at once, and a new period applies to the next change.
- R10: A line marked invalid by the VALID_MASK parameter never drives its output low, even when it is enabled. The default mask marks lines 13 and 21 to 23 invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pin_in | input | 144 | Pin bank levels; pins 120..143 feed lines 0..23 |
| irq_n | output | 24 | Per-line request toward the parent controller |

## Verification
A filter counter that runs wrong moves the cycle in which a level or a pulse appears. The bench therefore measures the exact edge index of every change against 2, 3+P and 4+P, and catches an off-by-one in the first measured window. An event machine stuck in EV_FIRE shows as a low output lasting more than one cycle, visible on the very next sample. A machine that ignores the filter-enable gate shows as a stray pulse within 4+P edges of a pin toggle. A register decode fault shows on the read port at once, or as an output that stays high because the line never leaves EV_OFF.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_FILTER = 8'h98;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 8'h9C;

    // glitch filter per line
    typedef enum logic {
        FLT_SETTLED,
        FLT_QUALIFY
    } flt_state_t;

    // event machine per line
    typedef enum logic [1:0] {
        EV_OFF,
        EV_LEVEL,
        EV_ARMED,
        EV_FIRE
    } ev_state_t;
endpackage

// File: rtl/pin_event_regs.sv
module pin_event_regs
    import pin_event_pkg::*;
#(
    parameter int LINES      = 24,
    parameter int PERIOD_W   = 8,
    parameter int PERIOD_RST = 255
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [LINES-1:0]    en,
    output logic [LINES-1:0]    mode,
    output logic [LINES-1:0]    filt,
    output logic [PERIOD_W-1:0] period
);
    localparam logic [PERIOD_W-1:0] PERIOD_INIT = PERIOD_W'(PERIOD_RST);

    logic [LINES-1:0]    en_q, mode_q, filt_q;
    logic [PERIOD_W-1:0] period_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            mode_q   <= '0;
            filt_q   <= '0;
            period_q <= PERIOD_INIT;
        end else if (we) begin
            case (addr)
                OFS_ENABLE: en_q     <= wdata[LINES-1:0];
                OFS_MODE:   mode_q   <= wdata[LINES-1:0];
                OFS_FILTER: filt_q   <= wdata[LINES-1:0];
                OFS_PERIOD: period_q <= wdata[PERIOD_W-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_ENABLE: rdata[LINES-1:0]    = en_q;
            OFS_MODE:   rdata[LINES-1:0]    = mode_q;
            OFS_FILTER: rdata[LINES-1:0]    = filt_q;
            OFS_PERIOD: rdata[PERIOD_W-1:0] = period_q;
            default:    rdata = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:LINES];

    assign en     = en_q;
    assign mode   = mode_q;
    assign filt   = filt_q;
    assign period = period_q;
endmodule

// File: rtl/pin_event_filter.sv
module pin_event_filter
    import pin_event_pkg::*;
#(
    parameter int PERIOD_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin,
    input  logic [PERIOD_W-1:0] period,
    output logic                raw,
    output logic                level,
    output logic                changed
);
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign raw = sync_q[SYNC_STAGES-1];

    flt_state_t          state_q, state_d;
    logic [PERIOD_W-1:0] cnt_q, cnt_d;
    logic                stable_q, stable_d, prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FLT_SETTLED;
            cnt_q    <= '0;
            stable_q <= 1'b0;
            prev_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            stable_q <= stable_d;
            prev_q   <= stable_q;
        end
    end

    // next state: count consecutive differing samples, accept at P+1
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        stable_d = stable_q;
        unique case (state_q)
            FLT_SETTLED: begin
                if (raw != stable_q) begin
                    if (cnt_q >= period) begin
                        stable_d = raw;
                        cnt_d    = '0;
                    end else begin
                        state_d = FLT_QUALIFY;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
            end
            FLT_QUALIFY: begin
                if (raw == stable_q) begin
                    state_d = FLT_SETTLED;
                    cnt_d   = '0;
                end else if (cnt_q >= period) begin
                    state_d  = FLT_SETTLED;
                    stable_d = raw;
                    cnt_d    = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    assign level   = stable_q;
    assign changed = stable_q ^ prev_q;
endmodule

// File: rtl/pin_event_line.sv
module pin_event_line
    import pin_event_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode,
    input  logic filt,
    input  logic raw,
    input  logic level,
    input  logic changed,
    output logic out_n
);
    ev_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!en) begin
            state_d = EV_OFF;
        end else if (!mode) begin
            state_d = EV_LEVEL;
        end else if (!filt) begin
            state_d = EV_OFF;
        end else if (changed && state_q != EV_FIRE) begin
            state_d = EV_FIRE;
        end else begin
            state_d = EV_ARMED;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            EV_OFF:   out_n = 1'b1;
            EV_LEVEL: out_n = filt ? level : raw;
            EV_ARMED: out_n = 1'b1;
            EV_FIRE:  out_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
    import pin_event_pkg::*;
#(
    parameter int                IRQ_BASE    = 120,
    parameter int                LINES       = 24,
    parameter logic [LINES-1:0]  VALID_MASK  = 24'h1FDFFF,
    parameter int                PERIOD_W    = 8,
    parameter int                PERIOD_RST  = 255,
    parameter int                SYNC_STAGES = 2,
    localparam int               PIN_COUNT   = IRQ_BASE + LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [LINES-1:0]     irq_n
);
    logic [LINES-1:0]    en_q, mode_q, filt_q;
    logic [PERIOD_W-1:0] period_q;
    logic [LINES-1:0]    line_pin;

    assign line_pin = pin_in[IRQ_BASE +: LINES];

    logic unused_pins;
    assign unused_pins = ^pin_in[IRQ_BASE-1:0];

    pin_event_regs #(
        .LINES      (LINES),
        .PERIOD_W   (PERIOD_W),
        .PERIOD_RST (PERIOD_RST)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .en     (en_q),
        .mode   (mode_q),
        .filt   (filt_q),
        .period (period_q)
    );

    for (genvar k = 0; k < LINES; k++) begin : g_line
        if (VALID_MASK[k]) begin : g_valid
            logic raw, level, changed;

            pin_event_filter #(
                .PERIOD_W    (PERIOD_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_filter (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin     (line_pin[k]),
                .period  (period_q),
                .raw     (raw),
                .level   (level),
                .changed (changed)
            );

            pin_event_line u_event (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en_q[k]),
                .mode    (mode_q[k]),
                .filt    (filt_q[k]),
                .raw     (raw),
                .level   (level),
                .changed (changed),
                .out_n   (irq_n[k])
            );
        end else begin : g_hole
            logic unused_line;
            assign unused_line = en_q[k] ^ mode_q[k] ^ filt_q[k] ^ line_pin[k];
            assign irq_n[k]    = 1'b1;
        end
    end
endmodule

// File: rtl/pin_event_unit_sva.sv
module pin_event_unit_sva #(
    parameter int               LINES      = 24,
    parameter logic [LINES-1:0] VALID_MASK = 24'h1FDFFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [LINES-1:0] en,
    input logic [LINES-1:0] mode,
    input logic [LINES-1:0] filt,
    input logic [LINES-1:0] irq_n
);
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable({en, mode, filt}));

    assert_disabled_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(en | $past(en))) & ~irq_n) == '0);

    assert_invalid_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (~VALID_MASK & ~irq_n) == '0);

    for (genvar k = 0; k < LINES; k++) begin : g_chk
        assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (en[k] && mode[k] && filt[k] && $past(en[k] && mode[k] && filt[k]) && !irq_n[k])
            |=> irq_n[k]);

        assert_nofilter_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (en[k] && mode[k] && !filt[k] && $past(en[k] && mode[k] && !filt[k]))
            |-> irq_n[k]);
    end
endmodule

bind pin_event_unit pin_event_unit_sva #(
    .LINES      (LINES),
    .VALID_MASK (VALID_MASK)
) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .en     (en_q),
    .mode   (mode_q),
    .filt   (filt_q),
    .irq_n  (irq_n)
);

// File: tb/pin_event_unit_test.sv
module pin_event_unit_test;
    localparam int BASE  = 120;
    localparam int LINES = 24;
    localparam int PINS  = BASE + LINES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = 8'h00;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic [PINS-1:0]   pins = '0;
    logic [LINES-1:0]  irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_event_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pin_in    (pins),
        .irq_n     (irq_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic read_reg(input string req, input logic [7:0] a, input int exp);
        cfg_addr = a;
        #1;
        check_int(req, $sformatf("reg %0h", a), int'(cfg_rdata), exp);
    endtask

    // steps window edges; first = edge index of first output change, lows = low samples
    task automatic measure(input int line, input int window, input int drop_at,
                           output int first, output int lows);
        logic init;
        init  = irq_n[line];
        first = -1;
        lows  = 0;
        for (int i = 1; i <= window; i++) begin
            step();
            if (irq_n[line] !== init && first < 0) first = i;
            if (irq_n[line] == 1'b0) lows++;
            if (i == drop_at) pins[BASE+line] = 1'b0;
        end
    endtask

    task automatic t_reset_default_period();
        int f, l;
        read_reg("R1", 8'h90, 0);
        read_reg("R1", 8'h94, 0);
        read_reg("R1", 8'h98, 0);
        read_reg("R1", 8'h9C, 'hFF);
        check_int("R1", "outputs after reset", int'(irq_n), 'hFFFFFF);
        // R6 with reset period 255: line 0 filtered level
        write_reg(8'h98, 32'h1);
        write_reg(8'h90, 32'h1);
        repeat (4) step();
        pins[BASE+0] = 1'b1;
        measure(0, 270, 0, f, l);
        check_int("R6", "default period change edge", f, 258);
    endtask

    task automatic t_regs();
        write_reg(8'h90, 32'hFF123456);
        read_reg("R2", 8'h90, 'h123456);
        write_reg(8'h9C, 32'h1F5);
        read_reg("R2", 8'h9C, 'hF5);
        write_reg(8'hA0, 32'hFFFFFFFF);
        write_reg(8'h00, 32'hFFFFFFFF);
        write_reg(8'h91, 32'hFFFFFFFF);
        read_reg("R2", 8'h90, 'h123456);
        read_reg("R2", 8'h94, 0);
        read_reg("R2", 8'h98, 1);
        read_reg("R2", 8'h9C, 'hF5);
        write_reg(8'h90, 32'h0);
        write_reg(8'h98, 32'h0);
        repeat (3) step();
    endtask

    task automatic t_disabled();
        int f, l;
        pins[BASE+4] = 1'b1;
        measure(4, 8, 0, f, l);
        pins[BASE+4] = 1'b0;
        measure(4, 8, 0, f, l);
        check_int("R4", "disabled line low samples", l, 0);
        check_int("R4", "disabled line output", int'(irq_n[4]), 1);
    endtask

    task automatic t_raw_level();
        int f, l;
        write_reg(8'h90, 32'h0000_000C); // lines 2 and 3 level, no filter
        repeat (4) step();
        check_int("R5", "line 3 low level", int'(irq_n[3]), 0);
        pins[BASE+3] = 1'b1;
        measure(3, 10, 0, f, l);
        check_int("R5", "raw level change edge", f, 2);
        check_int("R3", "line 2 unaffected by pin 123", int'(irq_n[2]), 0);
        check_int("R3", "line 3 follows pin 123", int'(irq_n[3]), 1);
    endtask

    task automatic t_filter_level();
        int f, l;
        write_reg(8'h9C, 32'd3);
        write_reg(8'h98, 32'h0000_0060);
        write_reg(8'h90, 32'h0000_006C);
        repeat (4) step();
        pins[BASE+5] = 1'b1;
        measure(5, 12, 0, f, l);
        check_int("R6", "filtered change edge P=3", f, 6);
        // glitch of 3 cycles rejected
        pins[BASE+6] = 1'b1;
        measure(6, 15, 3, f, l);
        check_int("R6", "3-cycle glitch rejected", f, -1);
        // 4 cycles accepted
        pins[BASE+6] = 1'b1;
        measure(6, 15, 4, f, l);
        check_int("R6", "4-cycle pulse accepted edge", f, 6);
    endtask

    task automatic t_edge();
        int f, l;
        write_reg(8'h9C, 32'd2);
        write_reg(8'h94, 32'h0000_0080);
        write_reg(8'h98, 32'h0000_0080);
        write_reg(8'h90, 32'h0000_0080);
        repeat (4) step();
        check_int("R7", "armed line idle high", int'(irq_n[7]), 1);
        pins[BASE+7] = 1'b1;
        measure(7, 20, 0, f, l);
        check_int("R7", "rise pulse edge", f, 6);
        check_int("R7", "rise pulse width", l, 1);
        pins[BASE+7] = 1'b0;
        measure(7, 20, 0, f, l);
        check_int("R7", "fall pulse edge", f, 6);
        check_int("R7", "fall pulse width", l, 1);
    endtask

    task automatic t_edge_nofilter();
        int f, l, tot;
        write_reg(8'h94, 32'h0000_0100);
        write_reg(8'h98, 32'h0);
        write_reg(8'h90, 32'h0000_0100);
        repeat (4) step();
        pins[BASE+8] = 1'b1;
        measure(8, 20, 0, f, l);
        tot = l;
        pins[BASE+8] = 1'b0;
        measure(8, 20, 0, f, l);
        tot += l;
        check_int("R8", "both-edge without filter low samples", tot, 0);
    endtask

    task automatic t_shared_period();
        int f, l;
        write_reg(8'h94, 32'h0);
        write_reg(8'h9C, 32'd5);
        write_reg(8'h98, 32'h0000_0600);
        write_reg(8'h90, 32'h0000_0600);
        repeat (4) step();
        pins[BASE+9]  = 1'b1;
        pins[BASE+10] = 1'b1;
        measure(9, 10, 0, f, l);
        check_int("R9", "line 9 at P=5", f, 8);
        check_int("R9", "line 10 with line 9", int'(irq_n[10]), 1);
        write_reg(8'h9C, 32'd1);
        repeat (2) step();
        pins[BASE+9]  = 1'b0;
        pins[BASE+10] = 1'b0;
        measure(10, 10, 0, f, l);
        check_int("R9", "line 10 at P=1", f, 4);
        check_int("R9", "line 9 with line 10", int'(irq_n[9]), 0);
    endtask

    task automatic t_invalid();
        int f, l, tot;
        write_reg(8'h94, 32'h0);
        write_reg(8'h98, 32'h0);
        write_reg(8'h90, 32'h0000_2000);
        repeat (4) step();
        measure(13, 6, 0, f, l);
        tot = l;
        pins[BASE+13] = 1'b1;
        measure(13, 6, 0, f, l);
        tot += l;
        pins[BASE+13] = 1'b0;
        measure(13, 6, 0, f, l);
        tot += l;
        check_int("R10", "invalid line low samples", tot, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset_default_period();
        t_regs();
        t_disabled();
        t_raw_level();
        t_filter_level();
        t_edge();
        t_edge_nofilter();
        t_shared_period();
        t_invalid();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule